// File: doc/BRIEF.md
# Two-Function Configuration Command/Status Combiner

This block holds the configuration header registers of a device that presents two functions behind one shared bus interface. Each function keeps its own command register, its own status register and its own small set of header registers. The host reaches them through a simple dword-indexed port that carries a function number, a register index, byte enables and write data. Read data is returned in the same cycle.

The bus engine shares one parity-error driver, one system-error driver and one address decoder between the functions, so the block folds the functions' settings into single device-level controls. The parity-error drive enable is on if any function asks for it. The system-error drive enable works the same way. The address-decode hit is the OR of every function's base-address range hits. Error events from the bus engine come back into the status registers. A detected parity error is recorded in every function at once. The remaining error flags are private to the function the event belongs to. Bus-master permission stays per function.

Top module: `cfgmf_top`

## Requirements
- R1: `bus_master_en[f]` equals command bit 2 of function f, and a write to one function never changes another function's enable.
- R2: Command bits 3, 4, 5, 7 and 9 always read as zero in every function, and writing ones to them changes no output.
- R3: `perr_en` is the OR of command bit 6 over all implemented functions.
- R4: `serr_en` is the OR of command bit 8 over all implemented functions.
- R5: A pulse on `ev_serr` sets status bit 14 only in those functions whose command bit 8 is set.
- R6: A pulse on `ev_perr` sets status bit 15 in every function on the same clock edge.
- R7: Per-function event strobes set status bits 8 (`ev_mdpe`), 11 (`ev_sta`), 12 (`ev_rta`) and 13 (`ev_rma`) of the named function only.
- R8: Status bits 8 and 11–15 are write-one-to-clear. Status occupies bits 31:16 of index 1, so byte enable 3 covers status bits 15:8. Writing 0 leaves a bit unchanged, and an event arriving on the same edge as a clear leaves the bit set.
- R9: Read-only fields hold constants and ignore writes: status bits 10:9 read as 01 with bits 4, 5 and 7 zero, revision ID 0x03 (index 2 byte 0), cache line size 0x00, header type 0x80 (index 3 bytes 0 and 2), capabilities pointer 0x00 (index 13), interrupt pin f+1, Min_Gnt 0x04 and Max_Lat 0x10 (index 15 bytes 1, 2, 3), and the ID word at index 0 is {0x7A10+f, 0x1D0C}.
- R10: `dec_hit` is high when any bit of `bar_hit` is high and low otherwise.
- R11: Class code (index 2 bytes 3:1), latency timer (index 3 byte 1), subsystem vendor and device IDs (index 11 low and high halves) and interrupt line (index 15 byte 0) are separate per function, and only the byte lanes enabled by `cfg_be` are written.
- R12: An access with a function number of 2 or more reads 0xFFFFFFFF and its writes change nothing.
- R13: After reset every writable register and status flag is zero, so index 1 reads 0x02000000 and all combined outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_func | input | 3 | Function number of the access |
| cfg_idx | input | 6 | Dword register index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed function and index |
| ev_perr | input | 1 | Parity error detected on the bus |
| ev_serr | input | 1 | System error asserted on the bus |
| ev_mdpe | input | 2 | Per-function master data parity error |
| ev_sta | input | 2 | Per-function signaled target abort |
| ev_rta | input | 2 | Per-function received target abort |
| ev_rma | input | 2 | Per-function received master abort |
| bar_hit | input | 8 | Per-function, per-BAR range hits, function f at bits 4f+3:4f |
| bus_master_en | output | 2 | Per-function bus-master enable |
| perr_en | output | 1 | Shared parity-error drive enable |
| serr_en | output | 1 | Shared system-error drive enable |
| dec_hit | output | 1 | Shared address-decode hit |

## Verification
The assertions assume that `cfg_wr` is the only path that can change the command registers, so a shared enable that moves must have had a write on the previous edge. They also assume the event strobes last one clock per occurrence and are low during reset. The stimulus drives every write and every event pulse for exactly one clock, between falling edges, and keeps the strobes low while reset is held. A clear and an event collide only in the one scenario that checks set-over-clear priority.

// File: rtl/cfgmf_pkg.sv
package cfgmf_pkg;

    localparam int IDX_W  = 6;
    localparam int FUNC_W = 3;
    localparam int DW     = 32;
    localparam int BEW    = DW / 8;

    // dword indices decoded by the host
    localparam logic [IDX_W-1:0] IDX_ID     = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CMDSTS = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_MISC   = 6'd3;
    localparam logic [IDX_W-1:0] IDX_SUBSYS = 6'd11;
    localparam logic [IDX_W-1:0] IDX_CAPP   = 6'd13;
    localparam logic [IDX_W-1:0] IDX_INTR   = 6'd15;

    // command bit positions
    localparam int CMD_BME  = 2;
    localparam int CMD_PERR = 6;
    localparam int CMD_SERR = 8;
    // io space, memory space, bus master, parity response, serr enable
    localparam logic [15:0] CMD_WMASK = 16'h0147;

    // status bit positions
    localparam int STS_MDPE = 8;
    localparam int STS_STA  = 11;
    localparam int STS_RTA  = 12;
    localparam int STS_RMA  = 13;
    localparam int STS_SSE  = 14;
    localparam int STS_DPE  = 15;
    localparam logic [15:0] STS_W1C_MASK = 16'hF900;
    localparam logic [15:0] STS_RO_VAL   = 16'h0200;

    // fixed header constants
    localparam logic [15:0] VENDOR_ID   = 16'h1D0C;
    localparam logic [15:0] DEV_ID_BASE = 16'h7A10;
    localparam logic [7:0]  REV_ID      = 8'h03;
    localparam logic [7:0]  HDR_TYPE    = 8'h80;
    localparam logic [7:0]  CACHE_LINE  = 8'h00;
    localparam logic [7:0]  CAP_PTR     = 8'h00;
    localparam logic [7:0]  MIN_GNT     = 8'h04;
    localparam logic [7:0]  MAX_LAT     = 8'h10;

    typedef struct packed {
        logic mdpe;
        logic sta;
        logic rta;
        logic rma;
    } fn_evt_t;

    typedef struct packed {
        logic [15:0] cmd;
        logic [15:0] sts;
        logic [23:0] class_code;
        logic [7:0]  lat;
        logic [7:0]  int_line;
        logic [15:0] ssvid;
        logic [15:0] ssid;
    } fn_regs_t;

    function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BEW-1:0] be);
        logic [DW-1:0] res;
        res = old_w;
        for (int b = 0; b < BEW; b++) begin
            if (be[b]) res[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return res;
    endfunction

    function automatic logic [15:0] lane_mask16(input logic [1:0] be2);
        return {{8{be2[1]}}, {8{be2[0]}}};
    endfunction

endpackage

// File: rtl/cfgmf_func_regs.sv
module cfgmf_func_regs
    import cfgmf_pkg::*;
#(
    parameter int FUNC_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [BEW-1:0]   be,
    input  logic [DW-1:0]    wdata,
    input  fn_evt_t          ev,
    input  logic             perr_det,
    input  logic             serr_evt,
    output fn_regs_t         regs,
    output logic [DW-1:0]    rdata
);

    localparam logic [15:0] MY_DEV_ID  = 16'(DEV_ID_BASE + 16'(FUNC_ID));
    localparam logic [7:0]  MY_INT_PIN = 8'(FUNC_ID + 1);

    fn_regs_t      q, d;
    logic [15:0]   clr_v, set_v;
    logic [DW-1:0] cls_w, sub_w;

    always_comb begin
        d     = q;
        clr_v = '0;
        set_v = '0;
        cls_w = be_merge({q.class_code, 8'h00}, wdata, {be[3:1], 1'b0});
        sub_w = be_merge({q.ssid, q.ssvid}, wdata, be);
        if (wr_en) begin
            case (idx)
                IDX_CMDSTS: begin
                    d.cmd = ((q.cmd & ~lane_mask16(be[1:0])) |
                             (wdata[15:0] & lane_mask16(be[1:0]))) & CMD_WMASK;
                    clr_v = wdata[31:16] & lane_mask16(be[3:2]) & STS_W1C_MASK;
                end
                IDX_CLASS:  d.class_code = cls_w[31:8];
                IDX_MISC:   if (be[1]) d.lat = wdata[15:8];
                IDX_SUBSYS: {d.ssid, d.ssvid} = sub_w;
                IDX_INTR:   if (be[0]) d.int_line = wdata[7:0];
                default: ;
            endcase
        end
        set_v[STS_MDPE] = ev.mdpe;
        set_v[STS_STA]  = ev.sta;
        set_v[STS_RTA]  = ev.rta;
        set_v[STS_RMA]  = ev.rma;
        set_v[STS_SSE]  = serr_evt & q.cmd[CMD_SERR];
        set_v[STS_DPE]  = perr_det;
        // an event on the same edge as a clear wins
        d.sts = (q.sts & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_comb begin
        case (idx)
            IDX_ID:     rdata = {MY_DEV_ID, VENDOR_ID};
            IDX_CMDSTS: rdata = {q.sts | STS_RO_VAL, q.cmd};
            IDX_CLASS:  rdata = {q.class_code, REV_ID};
            IDX_MISC:   rdata = {8'h00, HDR_TYPE, q.lat, CACHE_LINE};
            IDX_SUBSYS: rdata = {q.ssid, q.ssvid};
            IDX_CAPP:   rdata = {24'h0, CAP_PTR};
            IDX_INTR:   rdata = {MAX_LAT, MIN_GNT, MY_INT_PIN, q.int_line};
            default:    rdata = '0;
        endcase
    end

    assign regs = q;

    // R5: signaled system error only rises after an serr event with enable set
    assert_sse_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(q.sts[STS_SSE]) |-> $past(serr_evt && q.cmd[CMD_SERR]));

    // R6: detected parity error recorded on the following edge
    assert_dpe_recorded_R6: assert property (@(posedge clk) disable iff (rst)
        perr_det |=> q.sts[STS_DPE]);

    // R7: private abort flag only rises on its own strobe
    assert_rma_private_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(q.sts[STS_RMA]) |-> $past(ev.rma));

    // R8: a set flag survives unless a one is written to it
    assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (q.sts[STS_RMA] && !(wr_en && idx == IDX_CMDSTS && be[3] && wdata[29]))
        |=> q.sts[STS_RMA]);

endmodule

// File: rtl/cfgmf_combine.sv
module cfgmf_combine #(
    parameter int NUM_FUNC = 2,
    parameter int NUM_BAR  = 4
) (
    input  logic [NUM_FUNC-1:0]         perr_req,
    input  logic [NUM_FUNC-1:0]         serr_req,
    input  logic [NUM_FUNC*NUM_BAR-1:0] bar_hit,
    output logic                        perr_en,
    output logic                        serr_en,
    output logic                        dec_hit
);

    localparam int NHIT = NUM_FUNC * NUM_BAR;

    logic [NUM_FUNC-1:0] fn_hit;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn_hit
        assign fn_hit[f] = |bar_hit[f*NUM_BAR +: NUM_BAR];
    end

    assign perr_en = |perr_req;
    assign serr_en = |serr_req;
    assign dec_hit = |fn_hit;

    always_comb begin
        assert_hit_width_R10: assert (NHIT > 0);
    end

endmodule

// File: rtl/cfgmf_top.sv
module cfgmf_top
    import cfgmf_pkg::*;
#(
    parameter int NUM_FUNC = 2,
    parameter int NUM_BAR  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr,
    input  logic [FUNC_W-1:0]           cfg_func,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  logic [BEW-1:0]              cfg_be,
    input  logic [DW-1:0]               cfg_wdata,
    output logic [DW-1:0]               cfg_rdata,
    input  logic                        ev_perr,
    input  logic                        ev_serr,
    input  logic [NUM_FUNC-1:0]         ev_mdpe,
    input  logic [NUM_FUNC-1:0]         ev_sta,
    input  logic [NUM_FUNC-1:0]         ev_rta,
    input  logic [NUM_FUNC-1:0]         ev_rma,
    input  logic [NUM_FUNC*NUM_BAR-1:0] bar_hit,
    output logic [NUM_FUNC-1:0]         bus_master_en,
    output logic                        perr_en,
    output logic                        serr_en,
    output logic                        dec_hit
);

    fn_regs_t            fn_q     [NUM_FUNC];
    logic [DW-1:0]       fn_rdata [NUM_FUNC];
    logic [NUM_FUNC-1:0] perr_req, serr_req;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        fn_evt_t ev_f;
        logic    wr_f;
        assign ev_f = '{mdpe: ev_mdpe[f], sta: ev_sta[f], rta: ev_rta[f], rma: ev_rma[f]};
        assign wr_f = cfg_wr && (cfg_func == FUNC_W'(f));

        cfgmf_func_regs #(.FUNC_ID(f)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_f),
            .idx      (cfg_idx),
            .be       (cfg_be),
            .wdata    (cfg_wdata),
            .ev       (ev_f),
            .perr_det (ev_perr),
            .serr_evt (ev_serr),
            .regs     (fn_q[f]),
            .rdata    (fn_rdata[f])
        );

        assign perr_req[f]      = fn_q[f].cmd[CMD_PERR];
        assign serr_req[f]      = fn_q[f].cmd[CMD_SERR];
        assign bus_master_en[f] = fn_q[f].cmd[CMD_BME];

        // R1: a write aimed elsewhere leaves this function's master enable alone
        assert_bme_isolated_R1: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_func != FUNC_W'(f)) |=> $stable(bus_master_en[f]));
    end

    cfgmf_combine #(.NUM_FUNC(NUM_FUNC), .NUM_BAR(NUM_BAR)) u_comb (
        .perr_req (perr_req),
        .serr_req (serr_req),
        .bar_hit  (bar_hit),
        .perr_en  (perr_en),
        .serr_en  (serr_en),
        .dec_hit  (dec_hit)
    );

    // unimplemented function numbers read as all ones
    always_comb begin
        cfg_rdata = '1;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (cfg_func == FUNC_W'(f)) cfg_rdata = fn_rdata[f];
        end
    end

    // R3: shared parity enable only moves after a configuration write
    assert_perr_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(perr_en) |-> $past(cfg_wr));

    // R4: shared system-error enable only moves after a configuration write
    assert_serr_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(serr_en) |-> $past(cfg_wr));

    // R12: writes to absent functions leave every control output unchanged
    assert_unimpl_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_func >= FUNC_W'(NUM_FUNC))
        |=> ($stable(perr_en) && $stable(serr_en) && $stable(bus_master_en)));

endmodule

// File: tb/tb_cfgmf_top.sv
module tb_cfgmf_top;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 2;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_idx;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        ev_perr, ev_serr;
    logic [NF-1:0] ev_mdpe, ev_sta, ev_rta, ev_rma;
    logic [NF*NB-1:0] bar_hit;
    logic [NF-1:0] bus_master_en;
    logic        perr_en, serr_en, dec_hit;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgmf_top dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_func(cfg_func), .cfg_idx(cfg_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_perr(ev_perr), .ev_serr(ev_serr), .ev_mdpe(ev_mdpe), .ev_sta(ev_sta),
        .ev_rta(ev_rta), .ev_rma(ev_rma), .bar_hit(bar_hit),
        .bus_master_en(bus_master_en), .perr_en(perr_en), .serr_en(serr_en), .dec_hit(dec_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int f, input int idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_func = 3'(f); cfg_idx = 6'(idx); cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int f, input int idx, output logic [31:0] d);
        cfg_func = 3'(f); cfg_idx = 6'(idx);
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse(input logic perr, input logic serr, input logic [NF-1:0] mdpe,
                         input logic [NF-1:0] sta, input logic [NF-1:0] rta, input logic [NF-1:0] rma);
        @(negedge clk);
        ev_perr = perr; ev_serr = serr; ev_mdpe = mdpe; ev_sta = sta; ev_rta = rta; ev_rma = rma;
        @(negedge clk);
        ev_perr = 0; ev_serr = 0; ev_mdpe = '0; ev_sta = '0; ev_rta = '0; ev_rma = '0;
    endtask

    task automatic clean();
        for (int f = 0; f < NF; f++) begin
            wr(f, 1, 4'b1111, 32'hFFFF_0000);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 1, v); chk("R13 f0 cmd/sts", v, 32'h0200_0000);
        rd(1, 1, v); chk("R13 f1 cmd/sts", v, 32'h0200_0000);
        chk("R13 outputs", {28'h0, bus_master_en, perr_en, serr_en}, 32'h0);
        chk("R13 dec_hit", {31'h0, dec_hit}, 32'h0);
        rd(0, 3, v); chk("R13 R9 f0 misc", v, 32'h0080_0000);
        rd(1, 15, v); chk("R13 R9 f1 intr", v, 32'h1004_0200);
    endtask

    task automatic t_bme();
        logic [31:0] v;
        wr(0, 1, 4'b0011, 32'h0000_0004);
        chk("R1 only f0", {30'h0, bus_master_en}, 32'h1);
        rd(1, 1, v); chk("R1 f1 cmd clear", {16'h0, v[15:0]}, 32'h0);
        wr(1, 1, 4'b0011, 32'h0000_0004);
        chk("R1 both", {30'h0, bus_master_en}, 32'h3);
        wr(0, 1, 4'b0011, 32'h0000_0000);
        chk("R1 only f1", {30'h0, bus_master_en}, 32'h2);
        wr(1, 1, 4'b0011, 32'h0000_0000);
    endtask

    task automatic t_ro_cmd();
        logic [31:0] v;
        wr(0, 1, 4'b0011, 32'h0000_02BC);
        rd(0, 1, v); chk("R2 ro cmd bits", {16'h0, v[15:0]}, 32'h0000_0004);
        chk("R2 outputs", {28'h0, bus_master_en, perr_en, serr_en}, 32'h4);
        wr(0, 1, 4'b0011, 32'h0000_0000);
    endtask

    task automatic t_perr();
        wr(1, 1, 4'b0011, 32'h0000_0040);
        chk("R3 f1 only", {31'h0, perr_en}, 32'h1);
        wr(1, 1, 4'b0011, 32'h0000_0000);
        chk("R3 none", {31'h0, perr_en}, 32'h0);
        wr(0, 1, 4'b0011, 32'h0000_0040);
        chk("R3 f0 only", {31'h0, perr_en}, 32'h1);
        wr(0, 1, 4'b0011, 32'h0000_0000);
    endtask

    task automatic t_serr();
        logic [31:0] v;
        clean();
        wr(1, 1, 4'b0011, 32'h0000_0100);
        chk("R4 f1 only", {31'h0, serr_en}, 32'h1);
        wr(1, 1, 4'b0011, 32'h0000_0000);
        wr(0, 1, 4'b0011, 32'h0000_0100);
        chk("R4 f0 only", {31'h0, serr_en}, 32'h1);
        pulse(0, 1, '0, '0, '0, '0);
        rd(0, 1, v); chk("R5 f0 enabled", {16'h0, v[31:16]}, 32'h4200);
        rd(1, 1, v); chk("R5 f1 disabled", {16'h0, v[31:16]}, 32'h0200);
        wr(0, 1, 4'b0011, 32'h0000_0000);
        chk("R4 none", {31'h0, serr_en}, 32'h0);
    endtask

    task automatic t_dpe();
        logic [31:0] v;
        clean();
        pulse(1, 0, '0, '0, '0, '0);
        rd(0, 1, v); chk("R6 f0", {16'h0, v[31:16]}, 32'h8200);
        rd(1, 1, v); chk("R6 f1", {16'h0, v[31:16]}, 32'h8200);
    endtask

    task automatic t_private();
        logic [31:0] v;
        clean();
        pulse(0, 0, 2'b01, 2'b01, 2'b10, 2'b10);
        rd(0, 1, v); chk("R7 f0", {16'h0, v[31:16]}, 32'h0B00);
        rd(1, 1, v); chk("R7 f1", {16'h0, v[31:16]}, 32'h3200);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        clean();
        pulse(1, 0, '0, '0, '0, 2'b11);
        wr(0, 1, 4'b1100, 32'h0000_0000);
        rd(0, 1, v); chk("R8 write zero keeps", {16'h0, v[31:16]}, 32'hA200);
        wr(0, 1, 4'b1000, 32'h8000_0000);
        rd(0, 1, v); chk("R8 clear bit15", {16'h0, v[31:16]}, 32'h2200);
        rd(1, 1, v); chk("R8 other fn kept", {16'h0, v[31:16]}, 32'hA200);
        wr(0, 1, 4'b0100, 32'hFFFF_0000);
        rd(0, 1, v); chk("R8 lane off keeps", {16'h0, v[31:16]}, 32'h2200);
        @(negedge clk);
        cfg_wr = 1; cfg_func = 3'd1; cfg_idx = 6'd1; cfg_be = 4'b1000; cfg_wdata = 32'h8000_0000;
        ev_perr = 1;
        @(negedge clk);
        cfg_wr = 0; ev_perr = 0;
        rd(1, 1, v); chk("R8 set beats clear", {16'h0, v[31:16]}, 32'hA200);
    endtask

    task automatic t_sep();
        logic [31:0] v;
        wr(0, 3, 4'b0010, 32'h0000_AB00);
        wr(1, 3, 4'b0010, 32'h0000_3300);
        rd(0, 3, v); chk("R11 f0 lat", v, 32'h0080_AB00);
        rd(1, 3, v); chk("R11 f1 lat", v, 32'h0080_3300);
        wr(0, 2, 4'b1110, 32'h0C03_3099);
        wr(1, 2, 4'b1000, 32'hFF00_0000);
        rd(0, 2, v); chk("R11 f0 class", v, 32'h0C03_3003);
        rd(1, 2, v); chk("R11 f1 class", v, 32'hFF00_0003);
        wr(0, 11, 4'b0011, 32'h1111_2222);
        wr(0, 11, 4'b1100, 32'h3333_4444);
        rd(0, 11, v); chk("R11 f0 subsys", v, 32'h3333_2222);
        rd(1, 11, v); chk("R11 f1 subsys", v, 32'h0000_0000);
        wr(1, 15, 4'b0001, 32'h0000_0055);
        wr(0, 15, 4'b0001, 32'h0000_0000);
        rd(1, 15, v); chk("R11 f1 int line", v, 32'h1004_0255);
        rd(0, 15, v); chk("R11 f0 int line", v, 32'h1004_0100);
    endtask

    task automatic t_ro_const();
        logic [31:0] v;
        wr(0, 2, 4'b0001, 32'hFFFF_FFFF);
        rd(0, 2, v); chk("R9 rev id", v, 32'h0C03_3003);
        wr(0, 3, 4'b1101, 32'hFFFF_FFFF);
        rd(0, 3, v); chk("R9 hdr/cache", v, 32'h0080_AB00);
        wr(0, 15, 4'b1110, 32'hFFFF_FFFF);
        rd(0, 15, v); chk("R9 pin/gnt/lat", v, 32'h1004_0100);
        wr(1, 13, 4'b1111, 32'hFFFF_FFFF);
        rd(1, 13, v); chk("R9 cap ptr", v, 32'h0);
        wr(0, 0, 4'b1111, 32'hFFFF_FFFF);
        rd(0, 0, v); chk("R9 f0 id", v, 32'h7A10_1D0C);
        rd(1, 0, v); chk("R9 f1 id", v, 32'h7A11_1D0C);
        clean();
        wr(1, 1, 4'b1100, 32'hFFFF_0000);
        rd(1, 1, v); chk("R9 status ro", {16'h0, v[31:16]}, 32'h0200);
    endtask

    task automatic t_hit();
        @(negedge clk); bar_hit = '0; #1;
        chk("R10 no hit", {31'h0, dec_hit}, 32'h0);
        for (int b = 0; b < NF*NB; b++) begin
            bar_hit = 8'(1 << b); #1;
            chk("R10 single hit", {31'h0, dec_hit}, 32'h1);
        end
        bar_hit = 8'hA5; #1;
        chk("R10 multi hit", {31'h0, dec_hit}, 32'h1);
        bar_hit = '0; #1;
        chk("R10 cleared", {31'h0, dec_hit}, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(0, 1, 4'b0011, 32'h0000_0144);
        wr(3, 1, 4'b1111, 32'hFFFF_FFFF);
        chk("R12 outputs kept", {28'h0, bus_master_en, perr_en, serr_en}, 32'h7);
        wr(5, 3, 4'b1111, 32'hFFFF_FFFF);
        rd(0, 3, v); chk("R12 f0 lat kept", v, 32'h0080_AB00);
        rd(2, 1, v); chk("R12 fn2 read", v, 32'hFFFF_FFFF);
        rd(7, 0, v); chk("R12 fn7 read", v, 32'hFFFF_FFFF);
        wr(0, 1, 4'b0011, 32'h0000_0000);
    endtask

    initial begin
        rst = 1; cfg_wr = 0; cfg_func = 0; cfg_idx = 0; cfg_be = 0; cfg_wdata = 0;
        ev_perr = 0; ev_serr = 0; ev_mdpe = '0; ev_sta = '0; ev_rta = '0; ev_rma = '0;
        bar_hit = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_bme();
        t_ro_cmd();
        t_perr();
        t_serr();
        t_dpe();
        t_private();
        t_w1c();
        t_sep();
        t_ro_const();
        t_hit();
        t_unimpl();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule